// File: doc/BRIEF.md
# USB Endpoint Transfer Payload Segmenter

This block handles the payload bookkeeping for one USB endpoint. A transfer is opened with a start pulse that carries a requested byte count, the endpoint's maximum packet size, a transfer-type code and a bus-speed code.

The block works in one of two directions:

- **Transmit direction.** The block emits a stream of per-packet byte counts. Every packet is full-sized except the last one.
- **Receive direction.** The block accepts a stream of received packet lengths and checks each one against the request.

In both directions it keeps count of the bytes still outstanding and decides when the transfer is over. It reports one of three outcomes:

- completion,
- completion on a short packet,
- an overflow error that aborts the transfer.

Both packet streams use valid/ready. In the transmit stream, once `tx_valid` is high the block holds `tx_len` and `tx_last` steady until `tx_ready` is seen high at a clock edge. In the receive stream, `rx_ready` is high for the whole time a receive transfer is open, and a length is taken on every edge where `rx_valid` and `rx_ready` are both high. The sender may leave `rx_valid` low for any number of cycles. Control and status pins are plain levels or one-cycle pulses.

Top module: `xfer_segmenter`

## Requirements

Field encodings used below:
- `kind`: 0 = control, 1 = bulk, 2 = interrupt, 3 = isochronous.
- `speed`: 0 = low, 1 = full, 2 = high, 3 = reserved.
- `rx_mode`: 1 selects the receive direction.

- R1: `cfg_err` is a combinational level that is high unless `max_pkt` is legal for `kind` and `speed`. The legal settings are:
  - control: 8 at low speed; 8, 16, 32 or 64 at full speed; 64 at high speed.
  - bulk: 8, 16, 32 or 64 at full speed; 512 at high speed; nothing at low speed.
  - interrupt: any value from 1 up to 8 (low), 64 (full) or 1024 (high).
  - isochronous: any value from 1 up to 1023 (full) or 1024 (high); nothing at low speed.
  - reserved speed: nothing is legal.

  A start pulse while `cfg_err` is high opens no transfer.
- R2: Out of reset `busy`, `tx_valid`, `rx_ready`, `done`, `short_pkt` and `overflow` are low. A start pulse accepted in idle loads the 16-bit remaining count from `req_len` and latches `max_pkt`, `kind` and `zlp_en`. From the next cycle, `busy` is high, together with `tx_valid` (transmit) or `rx_ready` (receive).
- R3: In transmit, each emitted `tx_len` is the smaller of the remaining count and the maximum packet size. Every packet except the final one is therefore full-sized, and the final one carries the unpadded remainder. `tx_last` marks the final packet.
- R4: In transmit, when the remaining count reaches zero on a full-sized packet, one extra zero-length packet follows only if `zlp_en` was set at start. A request of 0 bytes sends a single zero-length packet.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_len` and `tx_last` stay unchanged.
- R6: A transfer ends with `done` when the accepted bytes equal the request. If that final packet was full-sized, `short_pkt` is low; if `zlp_en` was set, the transfer instead waits for a zero-length packet.
- R7: In receive, for a non-isochronous kind, a packet shorter than the maximum packet size (and not over the remaining count) ends the transfer with `done` and `short_pkt` both high.
- R8: A zero-length packet ends the transfer in every kind, with `short_pkt` high.
- R9: In receive, a packet longer than the maximum packet size, or longer than the remaining count, pulses `overflow`, returns to idle and gives no `done`. This covers an extra packet after the count is exhausted and an oversized final packet.
- R10: For the isochronous kind, a received packet of any length from 1 up to the maximum that leaves bytes remaining does not end the transfer.
- R11: `done`, `short_pkt` and `overflow` are one-cycle pulses issued in the cycle after the ending handshake, with `busy` already low. `done` and `overflow` never coincide. A start pulse while busy is ignored.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a transfer when idle and the configuration is legal |
| rx_mode | input | 1 | 1 = check received packets, 0 = emit packets |
| kind | input | 2 | Transfer type code |
| speed | input | 2 | Bus speed code |
| req_len | input | LEN_W | Requested byte count |
| max_pkt | input | MPS_W | Endpoint maximum packet size |
| zlp_en | input | 1 | Add a zero-length packet after an exact multiple |
| tx_valid | output | 1 | Emitted packet length is valid |
| tx_ready | input | 1 | Consumer takes the emitted packet |
| tx_len | output | MPS_W | Emitted packet byte count |
| tx_last | output | 1 | Emitted packet is the final one |
| rx_valid | input | 1 | Received packet length is valid |
| rx_ready | output | 1 | Block accepts received lengths |
| rx_len | input | MPS_W | Received packet byte count |
| busy | output | 1 | A transfer is open |
| cfg_err | output | 1 | Configuration inputs are illegal |
| done | output | 1 | Pulse: transfer completed |
| short_pkt | output | 1 | Pulse with done: final packet was shorter than maximum |
| overflow | output | 1 | Pulse: more data than expected, transfer aborted |

## Verification

The bench builds the block with its default widths: a 16-bit byte count and an 11-bit packet-size field. This brings the 1024-byte high-speed interrupt and isochronous sizes within reach, as well as a 65535-byte request that runs to 64 packets.

Directed cases cover:
- the legality table at its edges (1023 versus 1024, 9 at low speed, bulk at low speed),
- exact multiples with and without the trailing zero-length packet,
- extra and oversized packets,
- isochronous short packets that must not end a transfer.

Seeded random transfers in both directions then mix full, short, zero-length and oversized packets with random back-pressure.

// File: rtl/seg_pkg.sv
package seg_pkg;

  typedef enum logic [1:0] {
    XT_CTRL = 2'd0,
    XT_BULK = 2'd1,
    XT_INTR = 2'd2,
    XT_ISO  = 2'd3
  } xfer_kind_e;

  typedef enum logic [1:0] {
    SP_LOW  = 2'd0,
    SP_FULL = 2'd1,
    SP_HIGH = 2'd2,
    SP_RSVD = 2'd3
  } bus_speed_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_RECV = 2'd2
  } seg_state_e;

  // Outcome of applying one packet to the open transfer
  typedef struct packed {
    logic ends;       // transfer finishes legally on this packet
    logic over;       // packet carries more than allowed
    logic short_end;  // finishing packet was below the maximum size
  } step_res_t;

endpackage

// File: rtl/seg_cfg_check.sv
module seg_cfg_check
  import seg_pkg::*;
#(
  parameter int MPS_W = 11
) (
  input  xfer_kind_e       kind,
  input  bus_speed_e       speed,
  input  logic [MPS_W-1:0] mps,
  output logic             legal
);

  localparam logic [MPS_W-1:0] SZ8    = MPS_W'(8);
  localparam logic [MPS_W-1:0] SZ16   = MPS_W'(16);
  localparam logic [MPS_W-1:0] SZ32   = MPS_W'(32);
  localparam logic [MPS_W-1:0] SZ64   = MPS_W'(64);
  localparam logic [MPS_W-1:0] SZ512  = MPS_W'(512);
  localparam logic [MPS_W-1:0] SZ1023 = MPS_W'(1023);
  localparam logic [MPS_W-1:0] SZ1024 = MPS_W'(1024);

  logic             pow_set;   // one of the four small power-of-two sizes
  logic [MPS_W-1:0] ceiling;   // byte-granular upper bound, zero = none legal

  always_comb begin
    pow_set = (mps == SZ8) || (mps == SZ16) || (mps == SZ32) || (mps == SZ64);
    ceiling = '0;
    legal   = 1'b0;
    case (kind)
      XT_CTRL: begin
        case (speed)
          SP_LOW:  legal = (mps == SZ8);
          SP_FULL: legal = pow_set;
          SP_HIGH: legal = (mps == SZ64);
          default: legal = 1'b0;
        endcase
      end
      XT_BULK: begin
        case (speed)
          SP_FULL: legal = pow_set;
          SP_HIGH: legal = (mps == SZ512);
          default: legal = 1'b0;
        endcase
      end
      XT_INTR: begin
        case (speed)
          SP_LOW:  ceiling = SZ8;
          SP_FULL: ceiling = SZ64;
          SP_HIGH: ceiling = SZ1024;
          default: ceiling = '0;
        endcase
        legal = (ceiling != '0) && (mps != '0) && (mps <= ceiling);
      end
      default: begin
        case (speed)
          SP_FULL: ceiling = SZ1023;
          SP_HIGH: ceiling = SZ1024;
          default: ceiling = '0;
        endcase
        legal = (ceiling != '0) && (mps != '0) && (mps <= ceiling);
      end
    endcase
  end

endmodule

// File: rtl/seg_step.sv
module seg_step
  import seg_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int MPS_W = 11
) (
  input  logic [LEN_W-1:0] remain,
  input  logic [MPS_W-1:0] mps,
  input  logic [MPS_W-1:0] pkt_len,
  input  logic             iso,
  input  logic             zlp_en,
  output logic [MPS_W-1:0] fill_len,
  output logic [LEN_W-1:0] rem_next,
  output step_res_t        res
);

  logic [LEN_W-1:0] len_ext;
  logic [LEN_W-1:0] mps_ext;
  logic             is_short;
  logic             count_hit;

  always_comb begin
    len_ext  = LEN_W'(pkt_len);
    mps_ext  = LEN_W'(mps);
    // next packet to emit: full size, or the remainder when below it
    fill_len = (remain < mps_ext) ? MPS_W'(remain) : mps;
    rem_next = remain - len_ext;
    is_short = (pkt_len < mps);
    // exhausted count ends the transfer unless a trailing empty packet is owed
    count_hit = (rem_next == '0) && (is_short || !zlp_en);
    res.over      = (pkt_len > mps) || (len_ext > remain);
    res.ends      = !res.over &&
                    ((pkt_len == '0) || (is_short && !iso) || count_hit);
    res.short_end = res.ends && is_short;
  end

endmodule

// File: rtl/xfer_segmenter.sv
module xfer_segmenter
  import seg_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int MPS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rx_mode,
  input  logic [1:0]       kind,
  input  logic [1:0]       speed,
  input  logic [LEN_W-1:0] req_len,
  input  logic [MPS_W-1:0] max_pkt,
  input  logic             zlp_en,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [MPS_W-1:0] tx_len,
  output logic             tx_last,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [MPS_W-1:0] rx_len,
  output logic             busy,
  output logic             cfg_err,
  output logic             done,
  output logic             short_pkt,
  output logic             overflow
);

  seg_state_e       state_q;
  logic [LEN_W-1:0] remain_q;
  logic [MPS_W-1:0] mps_q;
  logic             iso_q;
  logic             zlp_q;
  logic             done_q, short_q, over_q;

  logic             cfg_ok;
  logic             launch;
  logic             fire;
  logic [MPS_W-1:0] fill_len;
  logic [MPS_W-1:0] pkt_len;
  logic [LEN_W-1:0] rem_next;
  step_res_t        res;

  seg_cfg_check #(.MPS_W(MPS_W)) cfg_i (
    .kind  (xfer_kind_e'(kind)),
    .speed (bus_speed_e'(speed)),
    .mps   (max_pkt),
    .legal (cfg_ok)
  );

  seg_step #(.LEN_W(LEN_W), .MPS_W(MPS_W)) step_i (
    .remain   (remain_q),
    .mps      (mps_q),
    .pkt_len  (pkt_len),
    .iso      (iso_q),
    .zlp_en   (zlp_q),
    .fill_len (fill_len),
    .rem_next (rem_next),
    .res      (res)
  );

  assign cfg_err   = !cfg_ok;
  assign busy      = (state_q != ST_IDLE);
  assign tx_valid  = (state_q == ST_SEND);
  assign rx_ready  = (state_q == ST_RECV);
  assign tx_len    = fill_len;
  assign pkt_len   = (state_q == ST_RECV) ? rx_len : fill_len;
  assign tx_last   = tx_valid && res.ends;
  assign done      = done_q;
  assign short_pkt = short_q;
  assign overflow  = over_q;

  assign launch = start && (state_q == ST_IDLE) && cfg_ok;
  assign fire   = (tx_valid && tx_ready) || (rx_ready && rx_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      mps_q    <= '0;
      iso_q    <= 1'b0;
      zlp_q    <= 1'b0;
      done_q   <= 1'b0;
      short_q  <= 1'b0;
      over_q   <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      short_q <= 1'b0;
      over_q  <= 1'b0;
      if (launch) begin
        state_q  <= rx_mode ? ST_RECV : ST_SEND;
        remain_q <= req_len;
        mps_q    <= max_pkt;
        iso_q    <= (xfer_kind_e'(kind) == XT_ISO);
        zlp_q    <= zlp_en;
      end else if (fire) begin
        remain_q <= rem_next;
        if (res.over) begin
          state_q <= ST_IDLE;
          over_q  <= 1'b1;
        end else if (res.ends) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          short_q <= res.short_end;
        end
      end
    end
  end

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_len) && $stable(tx_last)));

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && overflow));

  // R11
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || overflow) |-> !busy);

  // R1
  cfg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cfg_err && !busy) |=> !busy);

  // R3
  tx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_len <= mps_q));

  // R9
  rx_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && (rx_len > mps_q)) |=> (overflow && !done));

  // R11
  short_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_pkt |-> done);

endmodule

// File: tb/xfer_segmenter_tb.sv
module xfer_segmenter_tb_top;

  localparam int LW = 16;
  localparam int MW = 11;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, start, rx_mode, zlp_en, tx_ready, rx_valid;
  logic [1:0]    kind, speed;
  logic [LW-1:0] req_len;
  logic [MW-1:0] max_pkt, rx_len, tx_len;
  logic          tx_valid, tx_last, rx_ready, busy, cfg_err, done, short_pkt, overflow;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;

  xfer_segmenter #(.LEN_W(LW), .MPS_W(MW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_mode(rx_mode), .kind(kind),
    .speed(speed), .req_len(req_len), .max_pkt(max_pkt), .zlp_en(zlp_en),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_len(tx_len), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_len(rx_len), .busy(busy),
    .cfg_err(cfg_err), .done(done), .short_pkt(short_pkt), .overflow(overflow)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic bit legal_cfg(int k, int s, int m);
    bit p = (m == 8) || (m == 16) || (m == 32) || (m == 64);
    if (s == 3) return 1'b0;
    case (k)
      0: return (s == 0) ? (m == 8) : (s == 1) ? p : (m == 64);
      1: return (s == 0) ? 1'b0 : (s == 1) ? p : (m == 512);
      2: return (m >= 1) && (m <= ((s == 0) ? 8 : (s == 1) ? 64 : 1024));
      default: return (s != 0) && (m >= 1) && (m <= ((s == 1) ? 1023 : 1024));
    endcase
  endfunction

  function automatic int pick_mps(int k, int s);
    int sel = int'($urandom_range(0, 3));
    case (k)
      0: return (s == 0) ? 8 : (s == 2) ? 64 : (8 << sel);
      1: return (s == 2) ? 512 : (8 << sel);
      2: return int'($urandom_range(1, (s == 0) ? 8 : (s == 1) ? 64 : 1024));
      default: return int'($urandom_range(1, (s == 1) ? 1023 : 1024));
    endcase
  endfunction

  task automatic launch(bit rx, int k, int s, int rl, int m, bit z);
    @(negedge clk);
    rx_mode = rx; kind = k[1:0]; speed = s[1:0];
    req_len = rl[LW-1:0]; max_pkt = m[MW-1:0]; zlp_en = z; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // transmit side: expected lengths from the segmentation rules (R3, R4)
  task automatic run_tx(int rl, int m, bit z, string tag);
    int rem = rl;
    bit fin = 1'b0;
    int g = 0;
    int el;
    bit elast;
    int stalls;
    while (!fin && g < 100) begin
      g++;
      el    = (rem < m) ? rem : m;
      elast = (el < m) || ((el == rem) && !z);
      chk(tx_valid === 1'b1, {tag, " valid"}, int'(tx_valid), 1);
      chk(int'(tx_len) == el, {tag, " len"}, int'(tx_len), el);
      chk(tx_last == elast, "R3 last flag", int'(tx_last), int'(elast));
      stalls = int'($urandom_range(0, 2));
      for (int i = 0; i < stalls; i++) begin
        tx_ready = 1'b0;
        @(negedge clk);
        chk(tx_valid && int'(tx_len) == el && tx_last == elast, "R5 hold", int'(tx_len), el);
      end
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
      rem -= el;
      if (elast) begin
        fin = 1'b1;
        chk(done && !busy && !overflow, {tag, " done"}, int'(done), 1);
        chk(short_pkt == (el < m), {tag, " short"}, int'(short_pkt), int'(el < m));
      end else begin
        chk(!done && busy, {tag, " midway"}, int'(done), 0);
      end
    end
    chk(fin, {tag, " finished"}, int'(fin), 1);
  endtask

  // one received packet with explicit expectations
  task automatic rx_feed(int len, bit e_done, bit e_short, bit e_over, string tag);
    chk(rx_ready === 1'b1, {tag, " ready"}, int'(rx_ready), 1);
    rx_valid = 1'b1; rx_len = len[MW-1:0];
    @(negedge clk);
    rx_valid = 1'b0;
    chk(done == e_done, {tag, " done"}, int'(done), int'(e_done));
    chk(short_pkt == e_short, {tag, " short"}, int'(short_pkt), int'(e_short));
    chk(overflow == e_over, {tag, " overflow"}, int'(overflow), int'(e_over));
    chk(busy == !(e_done || e_over), {tag, " busy"}, int'(busy), int'(!(e_done || e_over)));
  endtask

  // receive side: random lengths, expected outcome from the requirements
  task automatic run_rx(int rl, int m, bit iso, bit z);
    int rem = rl;
    bit fin = 1'b0;
    int g = 0;
    int r, ln, fl;
    bit ov, en, sh;
    string tag;
    while (!fin && g < 100) begin
      g++;
      fl = (rem < m) ? rem : m;
      r  = int'($urandom_range(0, 19));
      if (rem == 0)    ln = (r < 16) ? 0 : int'($urandom_range(1, 40));
      else if (r < 13) ln = fl;
      else if (r < 17) ln = int'($urandom_range(0, fl));
      else             ln = int'($urandom_range(0, m + 5));
      ov = (ln > m) || (ln > rem);
      sh = (ln < m);
      en = !ov && ((ln == 0) || (sh && !iso) || ((rem - ln == 0) && (sh || !z)));
      if (ov)                   tag = "R9 rand";
      else if (ln == 0)         tag = "R8 rand";
      else if (en && sh && !iso) tag = "R7 rand";
      else if (!en && iso && sh) tag = "R10 rand";
      else                      tag = "R6 rand";
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        chk(busy && !done && !overflow, "R6 idle gap", int'(busy), 1);
      end
      rx_feed(ln, en, en && sh, ov, tag);
      if (ov || en) fin = 1'b1;
      else rem -= ln;
    end
  endtask

  initial begin
    int unsigned seed = 32'd7411;
    int k, s, m, rl;
    void'($urandom(seed));
    rst_n = 1'b0; start = 1'b0; rx_mode = 1'b0; zlp_en = 1'b0; tx_ready = 1'b0;
    rx_valid = 1'b0; kind = 2'd1; speed = 2'd2; req_len = '0; max_pkt = MW'(512); rx_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    chk(!busy && !tx_valid && !rx_ready, "R2 reset idle", int'(busy), 0);
    chk(!done && !short_pkt && !overflow, "R2 reset pulses", int'(done), 0);

    // R1 legality edges
    begin
      int tk[10] = '{0, 0, 1, 1, 2, 2, 3, 3, 3, 0};
      int ts[10] = '{1, 2, 0, 2, 0, 2, 1, 1, 2, 3};
      int tm[10] = '{12, 64, 8, 512, 9, 1024, 1023, 1024, 1024, 8};
      for (int i = 0; i < 10; i++) begin
        kind = tk[i][1:0]; speed = ts[i][1:0]; max_pkt = tm[i][MW-1:0];
        #1;
        chk(cfg_err == !legal_cfg(tk[i], ts[i], tm[i]), "R1 legality", int'(cfg_err),
            int'(!legal_cfg(tk[i], ts[i], tm[i])));
      end
    end
    launch(1'b0, 1, 0, 40, 8, 1'b0);
    chk(!busy && !tx_valid, "R1 blocked start", int'(busy), 0);
    launch(1'b1, 3, 1, 40, 1024, 1'b0);
    chk(!busy && !rx_ready, "R1 blocked start rx", int'(busy), 0);

    // R11 start while busy is ignored, then R3 100/64
    launch(1'b0, 1, 1, 100, 64, 1'b0);
    chk(busy && tx_valid, "R2 launch", int'(busy), 1);
    start = 1'b1; req_len = LW'(5);
    @(negedge clk);
    start = 1'b0;
    run_tx(100, 64, 1'b0, "R11 restart ignored");

    // R4 exact multiple without and with trailing empty packet, and empty request
    launch(1'b0, 1, 1, 128, 64, 1'b0);
    run_tx(128, 64, 1'b0, "R4 no zlp");
    launch(1'b0, 1, 1, 128, 64, 1'b1);
    run_tx(128, 64, 1'b1, "R4 zlp");
    launch(1'b0, 0, 2, 0, 64, 1'b0);
    run_tx(0, 64, 1'b0, "R4 empty request");
    // R2 full 16-bit count
    launch(1'b0, 2, 2, 65535, 1024, 1'b0);
    run_tx(65535, 1024, 1'b0, "R2 wide count");

    // receive directed
    launch(1'b1, 1, 2, 1024, 512, 1'b0);
    rx_feed(512, 0, 0, 0, "R6 first");
    rx_feed(512, 1, 0, 0, "R6 exact");
    launch(1'b1, 1, 2, 1024, 512, 1'b1);
    rx_feed(512, 0, 0, 0, "R6 zlp first");
    rx_feed(512, 0, 0, 0, "R6 zlp waits");
    rx_feed(0, 1, 1, 0, "R8 zlp end");
    launch(1'b1, 1, 2, 1024, 512, 1'b1);
    rx_feed(512, 0, 0, 0, "R9 setup a");
    rx_feed(512, 0, 0, 0, "R9 setup b");
    rx_feed(5, 0, 0, 1, "R9 extra packet");
    launch(1'b1, 1, 1, 100, 64, 1'b0);
    rx_feed(64, 0, 0, 0, "R9 setup c");
    rx_feed(40, 0, 0, 1, "R9 oversized final");
    launch(1'b1, 2, 1, 100, 64, 1'b0);
    rx_feed(70, 0, 0, 1, "R9 above maximum");
    launch(1'b1, 1, 1, 100, 64, 1'b0);
    rx_feed(64, 0, 0, 0, "R7 setup");
    rx_feed(10, 1, 1, 0, "R7 short end");
    launch(1'b1, 3, 1, 250, 100, 1'b0);
    rx_feed(30, 0, 0, 0, "R10 iso short a");
    rx_feed(100, 0, 0, 0, "R10 iso full");
    rx_feed(100, 0, 0, 0, "R10 iso full b");
    rx_feed(20, 1, 1, 0, "R10 iso exact end");
    launch(1'b1, 3, 2, 900, 300, 1'b0);
    rx_feed(30, 0, 0, 0, "R10 iso short b");
    rx_feed(0, 1, 1, 0, "R8 iso zlp");

    // random transfers in both directions
    for (int t = 0; t < 120; t++) begin
      k = int'($urandom_range(0, 3));
      s = (k == 1 || k == 3) ? int'($urandom_range(1, 2)) : int'($urandom_range(0, 2));
      m = pick_mps(k, s);
      chk(legal_cfg(k, s, m), "R1 picked legal", 0, 1);
      rl = ($urandom_range(0, 3) == 0) ? m * int'($urandom_range(0, 4))
                                       : int'($urandom_range(0, 5 * m));
      if (t % 2 == 0) begin
        launch(1'b0, k, s, rl, m, 1'($urandom_range(0, 1)));
        run_tx(rl, m, zlp_en, "R3 random tx");
      end else begin
        launch(1'b1, k, s, rl, m, 1'($urandom_range(0, 1)));
        run_rx(rl, m, k == 3, zlp_en);
      end
      chk(!busy, "R11 idle after random", int'(busy), 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule